// File: doc/BRIEF.md
# Pump Array Calibration Controller

This controller steers a reconfigurable switched-capacitor pump built from a row of two-stage units. After reset it configures the pump as one long chain and keeps the pump clock running until the digitized output voltage reaches its target. It then stops the pump clock so that the pump input floats up towards the open-circuit voltage of the thermoelectric source, and samples that voltage through an ADC handshake once it has settled.

The settled sample is compared against three thresholds. The result picks one of four arrangements: a single chain, two parallel chains, four parallel chains, or eight parallel chains. Each arrangement keeps the product of per-stage capacitance and stage count constant. The chosen arrangement is decoded into per-unit chaining and output-tap enables, and is applied while the clock is still stopped. The pump then runs in user mode until a periodic timer or an explicit request starts the next calibration.

Top module: `pump_cal_ctrl`

## Requirements
- R1: Reset state: `mode`=0 (single chain of all units), `osc_en`=1, `adc_req`=0, `ser_en` has every bit set except the top bit, and `par_en` has only the top bit set.
- R2: After reset, `osc_en` stays 1 while `vpp_code` < `VPP_TGT`. On the first clock edge that sees `vpp_code` >= `VPP_TGT`, the controller enters calibration and `osc_en` becomes 0.
- R3: During calibration, `osc_en`=0 and `adc_req`=1. Each cycle with `adc_valid`=1 delivers one sample. A sample whose absolute difference from the previous sample of the same calibration is at most `SETTLE_TOL` ends the settle wait, and that sample is used.
- R4: Once `SETTLE_MAX` cycles have passed in a calibration, the next sample ends the settle wait whatever its distance from the previous one.
- R5: Mode encoding from the used sample `s`: mode 0 if `s` < lo, mode 1 if lo <= `s` < mid, mode 2 if mid <= `s` < hi, mode 3 if `s` >= hi. A sample equal to a threshold selects the higher mode.
- R6: With chain length L = `UNITS` >> `mode`, `ser_en[i]`=1 (unit i feeds unit i+1) exactly when (i+1) mod L != 0, and `par_en[i]` = !`ser_en[i]` (unit i drives the common output). So 2^mode chains run in parallel.
- R7: `mode`, `ser_en` and `par_en` change only on a clock edge whose preceding cycle had `osc_en`=0. The new arrangement appears on the same edge at which `osc_en` returns to 1 for user mode.
- R8: In user mode, `osc_en` stays 1 for exactly `RECAL_PERIOD` cycles, then a new calibration starts.
- R9: `cal_req`=1 in user mode starts calibration on the next edge (`osc_en` drops). `cal_req` during the initial ramp is ignored.
- R10: The threshold inputs are captured only while `rst_n`=0. Later changes on those inputs have no effect on mode selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; thresholds are captured while low |
| vpp_code | input | ADC_W | Digitized pump output voltage |
| thr_lo | input | ADC_W | Boundary between mode 0 and mode 1 |
| thr_mid | input | ADC_W | Boundary between mode 1 and mode 2 |
| thr_hi | input | ADC_W | Boundary between mode 2 and mode 3 |
| cal_req | input | 1 | Request an immediate recalibration in user mode |
| adc_req | output | 1 | Asks the ADC for input-voltage samples |
| adc_valid | input | 1 | One-cycle strobe marking a new sample |
| adc_code | input | ADC_W | Digitized pump input voltage |
| osc_en | output | 1 | Pump clock oscillator enable |
| mode | output | 2 | Applied arrangement (0..3) |
| ser_en | output | UNITS | Per-unit enable chaining a unit into the next one |
| par_en | output | UNITS | Per-unit enable tapping a unit onto the output node |

## Verification
The bench targets four kinds of corner case:
- Samples sitting exactly on a threshold and one code below it. A design that used a strict comparison would select the lower arrangement.
- A noisy source that never settles within tolerance. A design without the timeout path would hang in calibration with the pump clock stopped.
- The length of the user window. An off-by-one counter would shift every recalibration by a cycle.
- Threshold inputs changed after reset, and a calibration request during ramp-up. A design that reads live thresholds would pick the wrong arrangement, and one that honoured the early request would stop the pump before the output reached its target.

// File: rtl/pump_cal_pkg.sv
package pump_cal_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      ARR_X1 = 2'd0,
      ARR_X2 = 2'd1,
      ARR_X4 = 2'd2,
      ARR_X8 = 2'd3
   } arr_mode_e;

   typedef enum logic [1:0] {
      ST_RAMP   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_APPLY  = 2'd2,
      ST_USER   = 2'd3
   } ctl_state_e;
endpackage

// File: rtl/pump_mode_select.sv
module pump_mode_select #(
   parameter int ADC_W = 10
) (
   input  logic [ADC_W-1:0] code,
   input  logic [ADC_W-1:0] thr_lo,
   input  logic [ADC_W-1:0] thr_mid,
   input  logic [ADC_W-1:0] thr_hi,
   output logic [1:0]       sel
);
   import pump_cal_pkg::*;
   arr_mode_e pick;

   // equality at a boundary falls into the higher-voltage arrangement
   always_comb begin
      if (code >= thr_hi)       pick = ARR_X8;
      else if (code >= thr_mid) pick = ARR_X4;
      else if (code >= thr_lo)  pick = ARR_X2;
      else                      pick = ARR_X1;
   end

   assign sel = pick;
endmodule

// File: rtl/pump_settle_detect.sv
module pump_settle_detect #(
   parameter int ADC_W   = 10,
   parameter int TOL     = 4,
   parameter int TMO     = 4096,
   parameter bit USE_TOL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             smp_valid,
   input  logic [ADC_W-1:0] smp_code,
   output logic             done
);
   localparam int TMO_W = $clog2(TMO + 1);
   localparam logic [TMO_W-1:0] TMO_C = TMO_W'(TMO);

   logic [TMO_W-1:0] wait_cnt;
   logic             timed_out;
   logic             near;

   assign timed_out = (wait_cnt >= TMO_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wait_cnt <= '0;
      else if (!active)    wait_cnt <= '0;
      else if (!timed_out) wait_cnt <= wait_cnt + 1'b1;
   end

   generate
      if (USE_TOL) begin : g_tol
         localparam logic [ADC_W-1:0] TOL_C = ADC_W'(TOL);
         logic [ADC_W-1:0] prev;
         logic [ADC_W-1:0] gap;
         logic             have_prev;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev      <= '0;
               have_prev <= 1'b0;
            end else if (!active) begin
               have_prev <= 1'b0;
            end else if (smp_valid) begin
               prev      <= smp_code;
               have_prev <= 1'b1;
            end
         end

         always_comb gap = (smp_code >= prev) ? (smp_code - prev) : (prev - smp_code);
         assign near = have_prev && (gap <= TOL_C);
      end else begin : g_tmo_only
         logic unused_code;
         assign unused_code = ^smp_code;
         assign near = 1'b0;
      end
   endgenerate

   assign done = active && smp_valid && (near || timed_out);
endmodule

// File: rtl/pump_switch_decode.sv
module pump_switch_decode #(
   parameter int UNITS = 8
) (
   input  logic [1:0]       mode,
   output logic [UNITS-1:0] ser_en,
   output logic [UNITS-1:0] par_en
);
   localparam int IDX_W = $clog2(UNITS);

   logic [IDX_W:0] chain_len;
   logic [IDX_W:0] pos_mask;

   assign chain_len = (IDX_W + 1)'(UNITS) >> mode;
   assign pos_mask  = chain_len - 1'b1;

   generate
      for (genvar u = 0; u < UNITS; u++) begin : g_unit
         localparam logic [IDX_W:0] NEXT = (IDX_W + 1)'(u + 1);
         assign ser_en[u] = ((NEXT & pos_mask) != '0);
         assign par_en[u] = ~ser_en[u];
      end
   endgenerate
endmodule

// File: rtl/pump_cal_ctrl.sv
module pump_cal_ctrl #(
   parameter int ADC_W        = 10,
   parameter int UNITS        = 8,
   parameter int VPP_TGT      = 767,
   parameter int SETTLE_TOL   = 4,
   parameter int SETTLE_MAX   = 4096,
   parameter int RECAL_PERIOD = 1000000,
   parameter bit USE_TOL      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_W-1:0] vpp_code,
   input  logic [ADC_W-1:0] thr_lo,
   input  logic [ADC_W-1:0] thr_mid,
   input  logic [ADC_W-1:0] thr_hi,
   input  logic             cal_req,
   output logic             adc_req,
   input  logic             adc_valid,
   input  logic [ADC_W-1:0] adc_code,
   output logic             osc_en,
   output logic [1:0]       mode,
   output logic [UNITS-1:0] ser_en,
   output logic [UNITS-1:0] par_en
);
   import pump_cal_pkg::*;

   localparam int PER_W = (RECAL_PERIOD > 2) ? $clog2(RECAL_PERIOD) : 1;
   localparam logic [PER_W-1:0] PER_LAST = PER_W'(RECAL_PERIOD - 1);
   localparam logic [ADC_W-1:0] TGT_C    = ADC_W'(VPP_TGT);

   generate
      if (ADC_W < 4) begin : g_bad_adc
         $error("ADC_W must be at least 4");
      end
      if ((UNITS % 8) != 0 || (UNITS & (UNITS - 1)) != 0) begin : g_bad_units
         $error("UNITS must be a power of two and at least 8");
      end
      if (VPP_TGT >= (1 << ADC_W) || VPP_TGT < 1) begin : g_bad_tgt
         $error("VPP_TGT must fit in ADC_W bits");
      end
      if (SETTLE_TOL >= (1 << ADC_W)) begin : g_bad_tol
         $error("SETTLE_TOL must fit in ADC_W bits");
      end
      if (SETTLE_MAX < 1 || RECAL_PERIOD < 2) begin : g_bad_time
         $error("SETTLE_MAX >= 1 and RECAL_PERIOD >= 2 required");
      end
   endgenerate

   ctl_state_e       st;
   arr_mode_e        mode_q;
   arr_mode_e        pend_q;
   logic [PER_W-1:0] per_cnt;
   logic [ADC_W-1:0] lo_q, mid_q, hi_q;
   logic [1:0]       sel_raw;
   logic             settle_done;
   logic             settling;

   // thresholds are loaded only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= thr_lo;
         mid_q <= thr_mid;
         hi_q  <= thr_hi;
      end
   end

   assign settling = (st == ST_SETTLE);

   pump_settle_detect #(
      .ADC_W  (ADC_W),
      .TOL    (SETTLE_TOL),
      .TMO    (SETTLE_MAX),
      .USE_TOL(USE_TOL)
   ) settle_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (settling),
      .smp_valid(adc_valid),
      .smp_code (adc_code),
      .done     (settle_done)
   );

   pump_mode_select #(.ADC_W(ADC_W)) pick_i (
      .code   (adc_code),
      .thr_lo (lo_q),
      .thr_mid(mid_q),
      .thr_hi (hi_q),
      .sel    (sel_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_RAMP;
         mode_q  <= ARR_X1;
         pend_q  <= ARR_X1;
         per_cnt <= '0;
      end else begin
         unique case (st)
            ST_RAMP: begin
               if (vpp_code >= TGT_C) st <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_done) begin
                  pend_q <= arr_mode_e'(sel_raw);
                  st     <= ST_APPLY;
               end
            end
            ST_APPLY: begin
               // oscillator is still stopped here: safe point to swap switches
               mode_q  <= pend_q;
               per_cnt <= '0;
               st      <= ST_USER;
            end
            ST_USER: begin
               if (cal_req || per_cnt == PER_LAST) st <= ST_SETTLE;
               else                                per_cnt <= per_cnt + 1'b1;
            end
            default: st <= ST_RAMP;
         endcase
      end
   end

   assign osc_en  = (st == ST_RAMP) || (st == ST_USER);
   assign adc_req = settling;
   assign mode    = mode_q;

   pump_switch_decode #(.UNITS(UNITS)) dec_i (
      .mode  (mode_q),
      .ser_en(ser_en),
      .par_en(par_en)
   );
endmodule

// File: rtl/pump_cal_chk.sv
module pump_cal_chk #(
   parameter int UNITS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             osc_en,
   input logic             adc_req,
   input logic             cal_req,
   input logic [1:0]       mode,
   input logic [UNITS-1:0] ser_en,
   input logic [UNITS-1:0] par_en
);
   logic seen_cal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_cal <= 1'b0;
      else if (adc_req) seen_cal <= 1'b1;
   end

   // R3
   sample_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |-> !osc_en);

   // R6
   tap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(par_en) == (1 << mode));

   // R6
   top_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_en[UNITS-1] && !ser_en[UNITS-1]);

   // R7
   quiet_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ser_en) || !$stable(mode)) |-> !$past(osc_en));

   // R9
   user_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_cal && osc_en && cal_req) |=> !osc_en);
endmodule

bind pump_cal_ctrl pump_cal_chk #(.UNITS(UNITS)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .osc_en (osc_en),
   .adc_req(adc_req),
   .cal_req(cal_req),
   .mode   (mode),
   .ser_en (ser_en),
   .par_en (par_en)
);

// File: tb/pump_cal_ctrl_tb_top.sv
module pump_cal_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADC_W = 10;
   localparam int UNITS = 8;
   localparam int TGT   = 767;
   localparam int TOL   = 4;
   localparam int TMO   = 60;
   localparam int PER   = 200;
   localparam int TLO = 225, TMID = 430, THI = 737;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [ADC_W-1:0] vpp_code, thr_lo, thr_mid, thr_hi, adc_code;
   logic             cal_req, adc_req, adc_valid, osc_en;
   logic [1:0]       mode;
   logic [UNITS-1:0] ser_en, par_en;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done_flag = 0;

   // source model: 0 = slewing toward voc, 1 = already settled, 2 = noisy
   int src_kind = 0;
   int voc = 600;
   int vs  = 300;
   bit tog = 0;
   int acnt = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pump_cal_ctrl #(
      .ADC_W(ADC_W), .UNITS(UNITS), .VPP_TGT(TGT), .SETTLE_TOL(TOL),
      .SETTLE_MAX(TMO), .RECAL_PERIOD(PER), .USE_TOL(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .vpp_code(vpp_code), .thr_lo(thr_lo),
      .thr_mid(thr_mid), .thr_hi(thr_hi), .cal_req(cal_req), .adc_req(adc_req),
      .adc_valid(adc_valid), .adc_code(adc_code), .osc_en(osc_en), .mode(mode),
      .ser_en(ser_en), .par_en(par_en)
   );

   // behavioural source plus ADC: one sample every third cycle while requested
   always @(negedge clk) begin
      cycles++;
      if (osc_en) vs = voc / 2;
      if (adc_req === 1'b1) begin
         acnt++;
         if (acnt == 3) begin
            acnt = 0;
            adc_valid = 1'b1;
            if (src_kind == 1) adc_code = ADC_W'(voc);
            else if (src_kind == 2) begin
               tog = ~tog;
               adc_code = tog ? ADC_W'(voc + 20) : ADC_W'(voc - 20);
            end else begin
               vs = vs + (voc - vs + 1) / 2;
               adc_code = ADC_W'(vs);
            end
         end else adc_valid = 1'b0;
      end else begin
         acnt = 0;
         adc_valid = 1'b0;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_ser(int m);
      int len = UNITS >> m;
      int v = 0;
      for (int i = 0; i < UNITS; i++) if (((i + 1) % len) != 0) v |= (1 << i);
      return v;
   endfunction

   task automatic check_arr(string req, int m);
      check(req, "mode", int'(mode), m);
      check("R6", "ser_en", int'(ser_en), exp_ser(m));
      check("R6", "par_en", int'(par_en), (~exp_ser(m)) & ((1 << UNITS) - 1));
   endtask

   // waits with the clock stopped until user mode resumes; returns stopped cycles
   task automatic wait_user(output int off, output int mode_moves);
      logic [1:0] m0 = mode;
      off = 0;
      mode_moves = 0;
      while (osc_en == 1'b0 && off < 2000) begin
         if (mode != m0) mode_moves++;
         @(negedge clk);
         off++;
      end
   endtask

   task automatic cal_by_request(int kind, int v, output int off);
      int mv;
      src_kind = kind;
      voc = v;
      @(negedge clk);
      cal_req = 1'b1;
      @(negedge clk);
      cal_req = 1'b0;
      check("R9", "osc_en after user request", int'(osc_en), 0);
      wait_user(off, mv);
      check("R7", "mode moves while stopped", mv, 0);
   endtask

   task automatic t_reset();
      check("R1", "osc_en", int'(osc_en), 1);
      check("R1", "adc_req", int'(adc_req), 0);
      check_arr("R1", 0);
   endtask

   task automatic t_ramp();
      int off, mv;
      vpp_code = 10'd500;
      cal_req = 1'b1;
      @(negedge clk);
      cal_req = 1'b0;
      repeat (10) @(negedge clk);
      check("R2", "osc_en below target", int'(osc_en), 1);
      check("R9", "adc_req after ramp request", int'(adc_req), 0);
      vpp_code = ADC_W'(TGT);
      @(negedge clk);
      check("R2", "osc_en at target", int'(osc_en), 0);
      check("R3", "adc_req in calibration", int'(adc_req), 1);
      check("R7", "mode held at stop", int'(mode), 0);
      wait_user(off, mv);
      check("R7", "mode moves while stopped", mv, 0);
      check("R3", "settled before timeout", int'(off < TMO), 1);
      check_arr("R5", 2);
   endtask

   task automatic t_period();
      int n = 1;
      int off, mv;
      voc = 300;
      forever begin
         @(negedge clk);
         if (!osc_en) break;
         n++;
         if (n > 5000) break;
      end
      check("R8", "user window length", n, PER);
      wait_user(off, mv);
      check_arr("R8", 1);
   endtask

   task automatic t_request();
      int off;
      cal_by_request(0, 900, off);
      check_arr("R9", 3);
   endtask

   task automatic t_bounds();
      int off;
      cal_by_request(1, TMID, off);     check_arr("R5", 2);
      cal_by_request(1, TMID - 1, off); check_arr("R5", 1);
      cal_by_request(1, THI, off);      check_arr("R5", 3);
      cal_by_request(1, THI - 1, off);  check_arr("R5", 2);
      cal_by_request(1, TLO, off);      check_arr("R5", 1);
      cal_by_request(1, TLO - 1, off);  check_arr("R5", 0);
   endtask

   task automatic t_timeout();
      int off;
      cal_by_request(2, 600, off);
      check("R4", "stopped at least timeout", int'(off >= TMO), 1);
      check("R4", "timeout bounded", int'(off < TMO + 10), 1);
      check_arr("R4", 2);
   endtask

   task automatic t_thr_hold();
      int off;
      thr_lo = '0;
      thr_mid = '0;
      thr_hi = '0;
      cal_by_request(1, 300, off);
      check_arr("R10", 1);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (cycles > 100000 && !done_flag) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0;
      vpp_code = '0;
      cal_req = 1'b0;
      thr_lo = ADC_W'(TLO);
      thr_mid = ADC_W'(TMID);
      thr_hi = ADC_W'(THI);
      adc_valid = 1'b0;
      adc_code = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ramp();
      t_period();
      t_request();
      t_bounds();
      t_timeout();
      t_thr_hold();
      finish_run();
   end
endmodule